// File: doc/BRIEF.md
# Delta-Update Fully-Connected Layer Engine

This block evaluates one fully-connected neural layer over a sequence of input frames. It does not recompute every dot product on every frame. It keeps each neuron's raw accumulated result (before activation) and the input vector of the frame before. When an element arrives, the block compares it with the stored copy of the same element. If the element is unchanged, it is skipped: it costs no update cycle and causes no weight read. If the element has changed, the block computes the difference once. It then walks through the neurons, one per cycle, and adds that difference times the neuron's weight for that element to the neuron's stored result.

The first frame after reset, or after a restart pulse, is a seeding frame. Every element in it counts as changed, and each neuron starts from its bias. That frame therefore yields bias plus the full dot product. Inputs enter one per cycle over a valid/ready handshake. Weights and biases are loaded through a plain write port. When the last element of a frame has been processed, the neuron results stream out in neuron order, and a per-frame count reports how many elements were skipped.

Top module: `fc_delta_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `skipped` is 0.
- R2: The first frame after reset yields, for each neuron n, bias[n] + Σ x[j]·w[n][j]. Every element counts as changed in this frame.
- R3: In a later frame, each output equals a full recomputation, bias[n] + Σ x_new[j]·w[n][j], bit for bit, as long as no saturation occurred. This holds for any mix of changed and unchanged elements.
- R4: An element equal to its stored copy is accepted in one cycle. It causes no update cycle, and `in_ready` stays 1 on the next cycle. A frame identical to the previous one leaves every output unchanged.
- R5: A changed element takes exactly N_OUT update cycles, during which `in_ready` is 0. A frame with C changed elements therefore holds off input and output for C·N_OUT cycles in total.
- R6: After each frame, `skipped` equals the number of unchanged elements in that frame. It is 0 for a seeding frame and never exceeds N_IN.
- R7: A one-cycle `restart` pulse makes the next frame a seeding frame, computed in full from the current weights and biases.
- R8: Accumulation saturates at each step to the signed 32-bit limits: 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow.
- R9: Outputs stream in ascending neuron order, with `out_last` high only on neuron N_OUT-1. While `out_ready` is 0, `out_data` and `out_last` hold steady.
- R10: A write with `wr_bias`=0 stores `wr_data` as weight w[`wr_row`][`wr_col`]. A write with `wr_bias`=1 stores it as the bias of neuron `wr_row`. Weights, biases and inputs are 16-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Pulse: next frame is computed in full |
| wr_en | input | 1 | Weight/bias write strobe |
| wr_bias | input | 1 | 1 selects the bias array, 0 the weight array |
| wr_row | input | $clog2(N_OUT) | Neuron index of the write |
| wr_col | input | $clog2(N_IN) | Input index of a weight write |
| wr_data | input | DW | Write value, signed |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Engine accepts an input element |
| in_data | input | DW | Input element, signed, in index order |
| out_valid | output | 1 | Neuron result valid |
| out_ready | input | 1 | Consumer accepts a result |
| out_data | output | AW | Neuron raw result, signed |
| out_last | output | 1 | Marks neuron N_OUT-1 |
| skipped | output | $clog2(N_IN+1) | Unchanged elements in the last frame |

## Verification
The assertions check several properties on every cycle. An unchanged element is never followed by an update cycle, and a changed or seeding element always is. An update pass ends after its final neuron. Outputs hold under back-pressure, and the skip count stays within range. Other behaviours can only be shown by the bench's scenarios, because they need a reference result. These include the arithmetic equality between the delta-updated outputs and a full recomputation across frames with varying change patterns. They also include stale outputs after a weight edit without restart, the effect of restart, and saturation to both limits.

// File: rtl/fc_delta_engine.sv
module fc_delta_engine #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 8,
  parameter int DW    = 16,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       wr_en,
  input  logic                       wr_bias,
  input  logic [$clog2(N_OUT)-1:0]   wr_row,
  input  logic [$clog2(N_IN)-1:0]    wr_col,
  input  logic [DW-1:0]              wr_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DW-1:0]              in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [AW-1:0]              out_data,
  output logic                       out_last,
  output logic [$clog2(N_IN+1)-1:0]  skipped
);
  localparam int IW = $clog2(N_IN);
  localparam int NW = $clog2(N_OUT);
  localparam int CW = $clog2(N_IN+1);
  localparam logic [IW-1:0] LAST_J = IW'(N_IN-1);
  localparam logic [NW-1:0] LAST_N = NW'(N_OUT-1);
  localparam logic signed [AW+1:0] SMAX = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] SMIN = {3'b111, {(AW-1){1'b0}}};

  typedef enum logic [1:0] {S_IN, S_UPD, S_OUT} st_t;

  st_t              st;
  logic [IW-1:0]    j;
  logic [NW-1:0]    n;
  logic             full, pend;
  logic [CW-1:0]    skip_cnt;
  logic signed [DW:0] delta;
  logic [DW-1:0]    xold [N_IN];
  logic [AW-1:0]    acc  [N_OUT];
  logic [DW-1:0]    wmem [N_OUT][N_IN];
  logic [DW-1:0]    bmem [N_OUT];

  always_ff @(posedge clk)
    if (wr_en) begin
      if (wr_bias) bmem[wr_row] <= wr_data;
      else         wmem[wr_row][wr_col] <= wr_data;
    end

  assign in_ready  = (st == S_IN);
  assign out_valid = (st == S_OUT);
  assign out_data  = acc[n];
  assign out_last  = out_valid && (n == LAST_N);

  wire accept  = in_valid && in_ready;
  wire seed    = (j == '0) ? pend : full;
  wire changed = seed || (in_data != xold[j]);
  wire signed [DW:0] diff = $signed({in_data[DW-1], in_data}) - $signed({xold[j][DW-1], xold[j]});
  wire [CW-1:0] skip_base = (j == '0) ? '0 : skip_cnt;

  wire signed [2*DW:0]  prod = delta * $signed(wmem[n][j]);
  wire signed [AW-1:0]  base = (full && j == '0) ? {{(AW-DW){bmem[n][DW-1]}}, bmem[n]} : acc[n];
  wire signed [AW+1:0]  sum  = {{2{base[AW-1]}}, base} + {{(AW+1-2*DW){prod[2*DW]}}, prod};
  wire [AW-1:0] upd = (sum > SMAX) ? SMAX[AW-1:0] : (sum < SMIN) ? SMIN[AW-1:0] : sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IN; j <= '0; n <= '0; full <= 1'b1; pend <= 1'b1;
      skip_cnt <= '0; skipped <= '0; delta <= '0;
      for (int i = 0; i < N_IN; i++)  xold[i] <= '0;
      for (int i = 0; i < N_OUT; i++) acc[i]  <= '0;
    end else begin
      if (restart) pend <= 1'b1;
      else if (accept && j == '0) pend <= 1'b0;
      case (st)
        S_IN: if (accept) begin
          if (j == '0) full <= pend;
          skip_cnt <= skip_base + CW'(!changed);
          if (changed) begin
            xold[j] <= in_data;
            delta   <= seed ? $signed({in_data[DW-1], in_data}) : diff;
            n       <= '0;
            st      <= S_UPD;
          end else if (j == LAST_J) begin
            skipped <= skip_base + CW'(1);
            n       <= '0;
            st      <= S_OUT;
          end else j <= j + 1'b1;
        end
        S_UPD: begin
          acc[n] <= upd;
          if (n == LAST_N) begin
            n <= '0;
            if (j == LAST_J) begin
              skipped <= skip_cnt;
              st      <= S_OUT;
            end else begin
              j  <= j + 1'b1;
              st <= S_IN;
            end
          end else n <= n + 1'b1;
        end
        S_OUT: if (out_ready) begin
          if (n == LAST_N) begin
            n <= '0; j <= '0; st <= S_IN;
          end else n <= n + 1'b1;
        end
        default: st <= S_IN;
      endcase
    end
  end

  assert_skip_no_mac_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !changed |=> st != S_UPD);
  assert_change_mac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && changed |=> st == S_UPD && n == '0);
  assert_pass_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UPD && n == LAST_N |=> st != S_UPD);
  assert_seed_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && seed |=> st == S_UPD);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  assert_skip_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skipped <= CW'(N_IN));
endmodule

// File: tb/fc_delta_engine_tb.sv
`timescale 1ns/1ps
module fc_delta_engine_tb;
  localparam int N_IN = 16, N_OUT = 8, DW = 16, AW = 32;
  localparam int CW = $clog2(N_IN+1);

  logic clk = 0, rst_n = 0, restart = 0, wr_en = 0, wr_bias = 0;
  logic [$clog2(N_OUT)-1:0] wr_row = '0;
  logic [$clog2(N_IN)-1:0]  wr_col = '0;
  logic [DW-1:0] wr_data = '0, in_data = '0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_last;
  logic [AW-1:0] out_data;
  logic [CW-1:0] skipped;

  fc_delta_engine #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .wr_en(wr_en), .wr_bias(wr_bias),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .skipped(skipped));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, stalls = 0;
  int x [N_IN];
  int w [N_OUT][N_IN];
  int b [N_OUT];
  longint expv [N_OUT];

  task automatic chk(bit ok, string req, string what, longint act, longint ex);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, ex);
    end
  endtask

  task automatic wr(bit isb, int r, int c, int v);
    @(negedge clk);
    wr_en = 1; wr_bias = isb; wr_row = r[$clog2(N_OUT)-1:0];
    wr_col = c[$clog2(N_IN)-1:0]; wr_data = v[DW-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic model();
    for (int i = 0; i < N_OUT; i++) begin
      longint s = b[i];
      for (int k = 0; k < N_IN; k++) s += longint'(x[k]) * longint'(w[i][k]);
      if (s > 64'sd2147483647) s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
      expv[i] = s;
    end
  endtask

  task automatic send();
    stalls = 0;
    for (int k = 0; k < N_IN; k++) begin
      in_valid = 1; in_data = x[k][DW-1:0];
      while (!in_ready) begin stalls++; @(negedge clk); end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic collect(string req, int exp_skip, int exp_stall);
    for (int i = 0; i < N_OUT; i++) begin
      logic [AW-1:0] held;
      int guard = 0;
      while (!out_valid && guard < 1000) begin stalls++; guard++; @(negedge clk); end
      held = out_data;
      @(negedge clk);
      chk(out_valid && out_data == held, "R9", "hold under back-pressure", longint'($signed(out_data)), longint'($signed(held)));
      out_ready = 1;
      chk($signed(out_data) == expv[i], req, $sformatf("neuron %0d", i), longint'($signed(out_data)), expv[i]);
      chk(out_last == (i == N_OUT-1), "R9", $sformatf("last flag neuron %0d", i), out_last, (i == N_OUT-1));
      @(negedge clk);
      out_ready = 0;
    end
    chk(int'(skipped) == exp_skip, "R6", "skip count", skipped, exp_skip);
    chk(stalls == exp_stall, "R5", "update cycles", stalls, exp_stall);
    chk(in_ready && !out_valid, "R4", "ready for next frame", in_ready, 1);
  endtask

  task automatic t_reset();
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(skipped == 0, "R1", "skipped after reset", skipped, 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < N_OUT; i++) begin
      b[i] = i * 1000 - 3000;
      wr(1, i, 0, b[i]);
      for (int k = 0; k < N_IN; k++) begin
        w[i][k] = ((i * 37 + k * 11) % 201) - 100;
        wr(0, i, k, w[i][k]);
      end
    end
  endtask

  task automatic t_seed_frame();
    for (int k = 0; k < N_IN; k++) x[k] = k * 50 - 300;
    model(); send(); collect("R2 R10", 0, N_IN * N_OUT);
  endtask

  task automatic t_partial_change();
    x[3] = 777; x[7] = -912; x[15] = 5;
    model(); send(); collect("R3", N_IN - 3, 3 * N_OUT);
  endtask

  task automatic t_identical();
    model(); send(); collect("R4", N_IN, 0);
  endtask

  task automatic t_all_change();
    for (int k = 0; k < N_IN; k++) x[k] = 900 - k * 113;
    model(); send(); collect("R3", 0, N_IN * N_OUT);
  endtask

  task automatic t_stale_then_restart();
    model();
    b[0] = 12345; wr(1, 0, 0, b[0]);
    w[1][2] = 99; wr(0, 1, 2, w[1][2]);
    send(); collect("R4", N_IN, 0);
    @(negedge clk); restart = 1; @(negedge clk); restart = 0;
    model(); send(); collect("R7", 0, N_IN * N_OUT);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < N_OUT; i++) begin
      b[i] = 0; wr(1, i, 0, 0);
      for (int k = 0; k < N_IN; k++) begin
        w[i][k] = (i < N_OUT/2) ? 32767 : -32768;
        wr(0, i, k, w[i][k]);
      end
    end
    for (int k = 0; k < N_IN; k++) x[k] = 32767;
    @(negedge clk); restart = 1; @(negedge clk); restart = 0;
    model(); send(); collect("R8", 0, N_IN * N_OUT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_seed_frame();
    t_partial_change();
    t_identical();
    t_all_change();
    t_stale_then_restart();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule